// File: doc/BRIEF.md
# Packed Instruction Loop Buffer

This block keeps the last eight instruction words that the fetch path delivered, so that a loop can be issued again without another trip to memory. Each word is 60 bits wide and carries four 15-bit parcels. Every word is stored with its word address as a tag. A lookup gives a parcel address, which is a word address with two parcel-select bits appended below it. In the same cycle the block answers with a hit flag and the chosen parcel.

Because the whole word is stored, any of the 32 parcels held can be selected in any order, not only the next one in sequence. A new word replaces the oldest entry. An unconditional jump discards everything. A taken conditional branch leaves the contents as they are, so a short backward loop closed by a conditional branch keeps running out of the buffer.

Top module: `loop_buffer`

## Requirements
- R1: After reset no entry is valid: every lookup misses.
- R2: When `wr_en` is high at a clock edge, the word on `wr_word` is stored under the tag `wr_addr`. From the next cycle on, a lookup of any parcel address whose upper bits equal that tag hits.
- R3: The low two bits of `rd_paddr` select the parcel. Value 0 gives bits 59:45, 1 gives bits 44:30, 2 gives bits 29:15 and 3 gives bits 14:0.
- R4: A lookup whose upper bits match no valid tag drives `hit` low and `parcel` to zero.
- R5: The buffer holds eight words. A write to a new address when all eight are valid evicts the entry that was written earliest, and the other seven stay valid.
- R6: Lookups can visit parcels of different buffered words in any order, including backwards and across words, and every one of them hits with the right data.
- R7: `jmp_flush` high at a clock edge with no write invalidates every entry from the next cycle on.
- R8: `br_taken` has no effect on contents, hits or parcel data.
- R9: `jmp_flush` and `wr_en` high at the same edge leave only the newly written word valid.
- R10: Writing an address that is already held drops the older copy. Later lookups return the new data. The new copy takes the next slot in replacement order.
- R11: `hit` and `parcel` follow `rd_paddr` in the same cycle, with no register in the lookup path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store the fetched word |
| wr_addr | input | 12 | Word address of the fetched word |
| wr_word | input | 60 | Fetched word, four packed parcels |
| rd_paddr | input | 14 | Parcel address for lookup (word address and 2-bit parcel index) |
| jmp_flush | input | 1 | Unconditional jump: discard all entries |
| br_taken | input | 1 | Taken conditional branch (no effect on contents) |
| hit | output | 1 | Lookup address is held |
| parcel | output | 15 | Selected parcel, zero on a miss |

## Verification
The assertions assume that reset is applied before the first lookup. They also assume that only a write can add a tag, so at most one entry ever matches a given address. The duplicate-rewrite case checks exactly that. The flush properties assume that a flush without a write is followed by at least one lookup cycle before new words arrive. The bench drives every input on the falling edge, holds each value for a whole cycle, and makes every flush a single-cycle pulse. This keeps all of those conditions true, including during the eviction and rewrite sequences.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int PARCEL_W = 15;
    localparam int PARCELS  = 4;
    localparam int SEL_W    = $clog2(PARCELS);
    localparam int WORD_W   = PARCEL_W * PARCELS;
endpackage

// File: rtl/lb_tag_match.sv
module lb_tag_match #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 12
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic [DEPTH-1:0]            match
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == key);
    end
endmodule

// File: rtl/lb_parcel_sel.sv
module lb_parcel_sel
    import lb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]             match,
    input  logic [DEPTH-1:0][WORD_W-1:0] words,
    input  logic [SEL_W-1:0]             sel,
    output logic                         hit,
    output logic [PARCEL_W-1:0]          parcel
);
    logic [WORD_W-1:0]                 word_or;
    logic [PARCELS-1:0][PARCEL_W-1:0]  slices;

    always_comb begin
        word_or = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) word_or = word_or | words[i];
        end
    end

    // slice 0 is the most significant parcel
    for (genvar k = 0; k < PARCELS; k++) begin : g_slice
        assign slices[k] = word_or[WORD_W-1-k*PARCEL_W -: PARCEL_W];
    end

    assign hit    = |match;
    assign parcel = slices[sel];
endmodule

// File: rtl/loop_buffer.sv
module loop_buffer
    import lb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_word,
    input  logic [ADDR_W+SEL_W-1:0]    rd_paddr,
    input  logic                       jmp_flush,
    input  logic                       br_taken,
    output logic                       hit,
    output logic [PARCEL_W-1:0]        parcel
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]              valid;
        logic [DEPTH-1:0][ADDR_W-1:0]  tag;
        logic [DEPTH-1:0][WORD_W-1:0]  word;
        logic [PTR_W-1:0]              ptr;
    } state_t;

    state_t state_d, state_q;
    logic [DEPTH-1:0] rd_match, wr_match;
    logic [PTR_W-1:0] slot;

    lb_tag_match #(.DEPTH(DEPTH), .TAG_W(ADDR_W)) u_rd_match (
        .valid (state_q.valid),
        .tags  (state_q.tag),
        .key   (rd_paddr[ADDR_W+SEL_W-1:SEL_W]),
        .match (rd_match)
    );

    lb_tag_match #(.DEPTH(DEPTH), .TAG_W(ADDR_W)) u_wr_match (
        .valid (state_q.valid),
        .tags  (state_q.tag),
        .key   (wr_addr),
        .match (wr_match)
    );

    lb_parcel_sel #(.DEPTH(DEPTH)) u_sel (
        .match  (rd_match),
        .words  (state_q.word),
        .sel    (rd_paddr[SEL_W-1:0]),
        .hit    (hit),
        .parcel (parcel)
    );

    always_comb begin
        state_d = state_q;
        slot    = jmp_flush ? '0 : state_q.ptr;
        if (jmp_flush) begin
            state_d.valid = '0;
            state_d.ptr   = '0;
        end
        if (wr_en) begin
            if (!jmp_flush) state_d.valid = state_q.valid & ~wr_match;
            state_d.valid[slot] = 1'b1;
            state_d.tag[slot]   = wr_addr;
            state_d.word[slot]  = wr_word;
            state_d.ptr = (int'(slot) == DEPTH - 1) ? '0 : slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    a_r10_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match));
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> parcel == '0);
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_flush && !wr_en |=> !hit);
    a_r9_flush_write_one: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_flush && wr_en |=> $countones(state_q.valid) == 1);
    a_r8_branch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken && !jmp_flush && !wr_en |=> $stable(state_q.valid));
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q.valid != '0);
endmodule

// File: tb/loop_buffer_test.sv
module loop_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, jmp_flush, br_taken;
    logic [11:0] wr_addr;
    logic [59:0] wr_word;
    logic [13:0] rd_paddr;
    logic        hit;
    logic [14:0] parcel;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    loop_buffer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_word(wr_word), .rd_paddr(rd_paddr), .jmp_flush(jmp_flush),
        .br_taken(br_taken), .hit(hit), .parcel(parcel)
    );

    function automatic logic [14:0] pdat(input logic [11:0] a, input int k, input int salt);
        return 15'((int'(a) * 37 + k * 1001 + salt * 5003 + 7) & 32'h7fff);
    endfunction

    function automatic logic [59:0] mkword(input logic [11:0] a, input int salt);
        return {pdat(a, 0, salt), pdat(a, 1, salt), pdat(a, 2, salt), pdat(a, 3, salt)};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic [11:0] a, input int salt, input logic fl);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_word = mkword(a, salt); jmp_flush = fl;
        @(negedge clk);
        wr_en = 1'b0; jmp_flush = 1'b0;
    endtask

    task automatic look(input string req, input logic [11:0] a, input int k,
                        input logic exp_hit, input int salt);
        rd_paddr = {a, 2'(k)};
        #1;
        check(req, {15'd0, hit}, {15'd0, exp_hit});
        check(req, {1'b0, parcel}, exp_hit ? {1'b0, pdat(a, k, salt)} : 16'd0);
    endtask

    task automatic flush_only;
        @(negedge clk); jmp_flush = 1'b1;
        @(negedge clk); jmp_flush = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset;   // R1
        do_reset();
        look("R1", 12'h000, 0, 1'b0, 0);
        look("R1", 12'h123, 2, 1'b0, 0);
    endtask

    task automatic t_write_and_order;   // R2 R3 R11 R4
        do_reset();
        write(12'h040, 0, 1'b0);
        for (int k = 0; k < 4; k++) look("R3", 12'h040, k, 1'b1, 0);
        look("R2", 12'h040, 1, 1'b1, 0);
        look("R4", 12'h041, 0, 1'b0, 0);
        look("R11", 12'h040, 3, 1'b1, 0);   // same cycle as address change
    endtask

    task automatic t_any_order;   // R6
        do_reset();
        for (int i = 0; i < 8; i++) write(12'h100 + 12'(i), 0, 1'b0);
        for (int i = 7; i >= 0; i--)
            for (int k = 3; k >= 0; k--) look("R6", 12'h100 + 12'(i), k, 1'b1, 0);
        look("R6", 12'h103, 1, 1'b1, 0);
        look("R6", 12'h106, 0, 1'b1, 0);
    endtask

    task automatic t_evict;   // R5
        do_reset();
        for (int i = 0; i < 9; i++) write(12'h200 + 12'(i), 0, 1'b0);
        look("R5", 12'h200, 0, 1'b0, 0);
        for (int i = 1; i < 9; i++) look("R5", 12'h200 + 12'(i), 2, 1'b1, 0);
        write(12'h209, 0, 1'b0);
        look("R5", 12'h201, 0, 1'b0, 0);
        look("R5", 12'h202, 0, 1'b1, 0);
    endtask

    task automatic t_flush;   // R7 R8
        do_reset();
        write(12'h300, 0, 1'b0);
        write(12'h301, 0, 1'b0);
        @(negedge clk); br_taken = 1'b1;
        @(negedge clk); br_taken = 1'b0;
        look("R8", 12'h300, 0, 1'b1, 0);
        look("R8", 12'h301, 3, 1'b1, 0);
        flush_only();
        look("R7", 12'h300, 0, 1'b0, 0);
        look("R7", 12'h301, 3, 1'b0, 0);
    endtask

    task automatic t_flush_write;   // R9
        do_reset();
        write(12'h400, 0, 1'b0);
        write(12'h401, 0, 1'b0);
        write(12'h402, 0, 1'b1);
        look("R9", 12'h400, 0, 1'b0, 0);
        look("R9", 12'h401, 0, 1'b0, 0);
        look("R9", 12'h402, 1, 1'b1, 0);
    endtask

    task automatic t_rewrite;   // R10
        do_reset();
        for (int i = 0; i < 8; i++) write(12'h500 + 12'(i), 0, 1'b0);
        write(12'h503, 1, 1'b0);   // slot 0 reused: 500 evicted, old 503 dropped
        look("R10", 12'h503, 0, 1'b1, 1);
        look("R10", 12'h503, 3, 1'b1, 1);
        look("R10", 12'h500, 0, 1'b0, 0);
        write(12'h508, 0, 1'b0);   // slot 1: evicts 501
        look("R10", 12'h501, 0, 1'b0, 0);
        look("R10", 12'h502, 0, 1'b1, 0);
        look("R10", 12'h508, 2, 1'b1, 0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; jmp_flush = 1'b0; br_taken = 1'b0;
        wr_addr = '0; wr_word = '0; rd_paddr = '0;
        t_reset();
        t_write_and_order();
        t_any_order();
        t_evict();
        t_flush();
        t_flush_write();
        t_rewrite();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule